// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs the read side of a burst-capable memory. A host marks the start of a burst by pulling a latch strobe low. On that clock edge the sequencer captures the start address and a snapshot of the read configuration. It then counts an initial latency and delivers one word per word period. The word period is one or two clocks. An advance input, sampled only at the end of each period, decides whether the word address moves on or the current word is held.

Word addresses go out to a synchronous array, which answers in the same cycle. The returned word is passed to the data output while output-enable is low. Bursts come in three kinds: fixed 4-word bursts, fixed 8-word bursts in sequential or interleaved order, and continuous bursts that walk the whole array. A continuous burst from a start that is not 4-word aligned needs one extra wait state. A ready flag reports that wait state, either in the stalled cycle itself or one cycle ahead. A fresh latch strobe during a burst aborts it and starts over.

Top module: `brs_seq`

## Requirements
- R1: Out of reset, data_valid and dout_en are 0, dout is 0 and wait_n is 1.
- R2: A start is taken on a rising clock edge that samples lat_n low when the previous edge sampled it high. The start captures adr_in and all cfg_* inputs. Keeping lat_n low, or changing adr_in or cfg_* afterwards, has no effect on the running burst.
- R3: The first word of a burst is valid X rising edges after the start edge, where X = cfg_xlat + 5 (code 4'b0011 gives 8).
- R4: cfg_len selects the burst kind: 3'b010 gives 8 words, 3'b111 gives a continuous burst, and any other code gives 4 words.
- R5: In a fixed burst with cfg_ilv = 0, word n is read at group base + ((start offset + n) mod L). L is the burst length, and the group is the L-aligned block that holds the start address.
- R6: In a fixed burst with cfg_ilv = 1, word n is read at group base + (start offset XOR n).
- R7: A continuous burst reads start + n modulo 2^AW, so it wraps from the top address to 0.
- R8: cfg_y2 = 0 gives a word period of 1 clock and cfg_y2 = 1 gives 2 clocks. adv_n is sampled only on the last edge of a period. Low moves to the next word. High holds the word for one more full period. adv_n has no effect on other edges.
- R9: A fixed burst ends when adv_n is sampled low at the end of its last word. data_valid then falls on that edge.
- R10: While oe_n and adv_n are both high, the word address and the period counter are frozen. dout_en is 0 and dout reads 0 whenever oe_n is high. The burst resumes with oe_n low.
- R11: A continuous burst whose start address has bits [1:0] not equal to 00 inserts one cycle with data_valid = 0 between the latency and the first word. Aligned starts and fixed bursts never drive wait_n low.
- R12: With cfg_early = 0, wait_n is 0 in the inserted cycle. With cfg_early = 1, wait_n is 0 in the cycle before it. wait_n is never low for two cycles in a row.
- R13: A new start during a burst abandons the old one at once: data_valid is 0 from that edge on. The new burst follows R3 from the new address.
- R14: During a burst, mem_addr carries the current word address, data_valid is 1, and dout carries mem_rdata when oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 3 | Burst kind code |
| cfg_ilv | input | 1 | 1 = interleaved order for fixed bursts |
| cfg_y2 | input | 1 | 1 = two clocks per word |
| cfg_xlat | input | 4 | Initial latency code, latency = code + 5 |
| cfg_early | input | 1 | 1 = wait flag one cycle ahead of the stall |
| lat_n | input | 1 | Address latch strobe, active low |
| adr_in | input | AW | Start word address |
| adv_n | input | 1 | Advance request, active low |
| oe_n | input | 1 | Output enable, active low |
| mem_addr | output | AW | Word address to the array |
| mem_rdata | input | DW | Word returned by the array for mem_addr |
| dout | output | DW | Read data, 0 when not driven |
| dout_en | output | 1 | Data output drive enable |
| data_valid | output | 1 | Current cycle carries a burst word |
| wait_n | output | 1 | Ready flag, low marks a wait state |

## Verification
The riskiest overlap is a new latch strobe arriving on the same edge where the word period expires and adv_n is sampled low. Both the start logic and the advance logic want to update the word counter on that edge. The abort scenario places the strobe on exactly such an edge in the middle of an 8-word burst. It then checks that data_valid drops at once, that no stepped address from the old burst appears, and that the new burst's words come out at the new latency from the new address. A second overlap arises when adv_n is high on a non-sampling edge of a two-clock word period. The bench drives that case and checks that the hold begins only from the sampling edge.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XLAT  = 2'd1,
      ST_STALL = 2'd2,
      ST_DATA  = 2'd3
   } brs_state_e;

   typedef enum logic [1:0] {
      BL_4    = 2'd0,
      BL_8    = 2'd1,
      BL_CONT = 2'd2
   } brs_len_e;

   typedef struct packed {
      brs_len_e   len;
      logic       ilv;
      logic       y2;
      logic       early;
      logic [3:0] xcode;
   } brs_cfg_t;

   // burst kind code: 010 eight words, 111 continuous, others four words
   function automatic brs_len_e decode_len(input logic [2:0] code);
      case (code)
         3'b010:  return BL_8;
         3'b111:  return BL_CONT;
         default: return BL_4;
      endcase
   endfunction

endpackage

// File: rtl/brs_xlat_ctr.sv
module brs_xlat_ctr #(
   parameter int XOFS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [3:0] xcode,
   output logic       expired
);
   localparam int XMAX = 15 + XOFS;
   localparam int XW   = $clog2(XMAX + 1);

   if (XOFS < 1) begin : g_bad_xofs
      $error("brs_xlat_ctr: XOFS must be at least 1");
   end

   logic [XW-1:0] cnt;

   // loaded with latency-1 on the start edge, counts to zero (R3)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= XW'(xcode) + XW'(XOFS - 1);
      end else if (cnt != '0) begin
         cnt <= cnt - XW'(1);
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen #(
   parameter int AW = 8
) (
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     beat,
   input  brs_pkg::brs_len_e len,
   input  logic              ilv,
   output logic [AW-1:0]     addr
);
   if (AW < 3) begin : g_bad_aw
      $error("brs_addr_gen: AW must be at least 3");
   end

   logic [AW-1:0] lin;
   logic          cont;
   logic          wide;

   assign lin  = base + beat;
   assign cont = (len == brs_pkg::BL_CONT);
   assign wide = (len == brs_pkg::BL_8);

   // the low three bits are lanes inside a fixed group, the rest follow
   // the group base for fixed bursts and the linear sum for continuous (R5-R7)
   for (genvar i = 0; i < AW; i++) begin : g_bit
      if (i < 3) begin : g_lane
         logic in_grp;
         if (i < 2) begin : g_always
            assign in_grp = 1'b1;
         end else begin : g_wide
            assign in_grp = wide;
         end
         assign addr[i] = cont   ? lin[i] :
                          in_grp ? (ilv ? (base[i] ^ beat[i]) : lin[i]) :
                                   base[i];
      end else begin : g_upper
         assign addr[i] = cont ? lin[i] : base[i];
      end
   end

endmodule

// File: rtl/brs_ready_flag.sv
module brs_ready_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic early,
   input  logic stall_now,
   input  logic stall_next,
   output logic wait_n
);
   // early selects the cycle ahead of the stall, otherwise the stall itself
   assign wait_n = early ? !stall_next : !stall_now;

   p_wait_single_low_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !wait_n |=> wait_n);

endmodule

// File: rtl/brs_seq.sv
module brs_seq #(
   parameter int AW   = 8,
   parameter int DW   = 16,
   parameter int XOFS = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    cfg_len,
   input  logic          cfg_ilv,
   input  logic          cfg_y2,
   input  logic [3:0]    cfg_xlat,
   input  logic          cfg_early,
   input  logic          lat_n,
   input  logic [AW-1:0] adr_in,
   input  logic          adv_n,
   input  logic          oe_n,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] dout,
   output logic          dout_en,
   output logic          data_valid,
   output logic          wait_n
);
   import brs_pkg::*;

   if (DW < 1) begin : g_bad_dw
      $error("brs_seq: DW must be at least 1");
   end

   localparam logic [AW-1:0] LAST4 = AW'(3);
   localparam logic [AW-1:0] LAST8 = AW'(7);

   logic          lat_q;
   logic          start;
   brs_state_e    state;
   brs_cfg_t      cfg_q;
   logic [AW-1:0] base_q;
   logic [AW-1:0] beat;
   logic          ycnt;
   logic          x_done;
   logic          need_stall;
   logic          last_beat;
   logic          y_end;
   logic          susp;
   logic          stall_next;

   // start on the first low sample of the strobe (R2, R13)
   assign start      = !lat_n && lat_q;
   assign need_stall = (cfg_q.len == BL_CONT) && (base_q[1:0] != 2'b00);
   assign last_beat  = ((cfg_q.len == BL_4) && (beat == LAST4)) ||
                       ((cfg_q.len == BL_8) && (beat == LAST8));
   assign y_end      = (ycnt == cfg_q.y2);
   assign susp       = oe_n && adv_n;
   assign stall_next = (state == ST_XLAT) && x_done && need_stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= 1'b1;
         state  <= ST_IDLE;
         cfg_q  <= '{len: BL_4, ilv: 1'b0, y2: 1'b0, early: 1'b0, xcode: 4'd0};
         base_q <= '0;
         beat   <= '0;
         ycnt   <= 1'b0;
      end else begin
         lat_q <= lat_n;
         if (start) begin
            base_q <= adr_in;
            cfg_q  <= '{len: decode_len(cfg_len), ilv: cfg_ilv, y2: cfg_y2,
                        early: cfg_early, xcode: cfg_xlat};
            state  <= ST_XLAT;
            beat   <= '0;
            ycnt   <= 1'b0;
         end else begin
            case (state)
               ST_XLAT: begin
                  if (x_done) state <= need_stall ? ST_STALL : ST_DATA;
               end
               ST_STALL: state <= ST_DATA;
               ST_DATA: begin
                  if (!susp) begin
                     if (y_end) begin
                        ycnt <= 1'b0;
                        if (!adv_n) begin
                           if (last_beat) state <= ST_IDLE;
                           else           beat  <= beat + AW'(1);
                        end
                     end else begin
                        ycnt <= 1'b1;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   brs_xlat_ctr #(.XOFS(XOFS)) u_xlat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .xcode   (cfg_xlat),
      .expired (x_done)
   );

   brs_addr_gen #(.AW(AW)) u_addr (
      .base (base_q),
      .beat (beat),
      .len  (cfg_q.len),
      .ilv  (cfg_q.ilv),
      .addr (mem_addr)
   );

   brs_ready_flag u_rdy (
      .clk        (clk),
      .rst_n      (rst_n),
      .early      (cfg_q.early),
      .stall_now  (state == ST_STALL),
      .stall_next (stall_next),
      .wait_n     (wait_n)
   );

   assign data_valid = (state == ST_DATA);
   assign dout_en    = data_valid && !oe_n;
   assign dout       = dout_en ? mem_rdata : '0;

   p_xlat_to_data_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XLAT && x_done && !start && !need_stall) |=> (state == ST_DATA));

   p_four_beat_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && cfg_q.len == BL_4) |-> (beat <= LAST4));

   p_beat_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && adv_n && !start) |=> (beat == $past(beat)));

   p_suspend_freeze_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && susp && !start) |=>
         (state == ST_DATA && mem_addr == $past(mem_addr) && ycnt == $past(ycnt)));

   p_stall_one_cycle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STALL && !start) |=> (state == ST_DATA));

   p_fixed_never_waits_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.len != BL_CONT) |-> wait_n);

endmodule

// File: tb/tb_brs_seq.sv
module tb_brs_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_len = 3'b001;
   logic        cfg_ilv = 1'b0;
   logic        cfg_y2 = 1'b0;
   logic [3:0]  cfg_xlat = 4'd0;
   logic        cfg_early = 1'b0;
   logic        lat_n = 1'b1;
   logic [7:0]  adr_in = 8'h00;
   logic        adv_n = 1'b0;
   logic        oe_n = 1'b0;
   logic [7:0]  mem_addr;
   logic [15:0] mem_rdata;
   logic [15:0] dout;
   logic        dout_en;
   logic        data_valid;
   logic        wait_n;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   function automatic logic [15:0] data_of(input logic [7:0] a);
      return {a ^ 8'h5A, ~a};
   endfunction

   assign mem_rdata = data_of(mem_addr);

   brs_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
      .cfg_y2(cfg_y2), .cfg_xlat(cfg_xlat), .cfg_early(cfg_early),
      .lat_n(lat_n), .adr_in(adr_in), .adv_n(adv_n), .oe_n(oe_n),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dout(dout),
      .dout_en(dout_en), .data_valid(data_valid), .wait_n(wait_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_addr(input logic [7:0] s, input logic [2:0] lc,
                                           input bit ilv, input int b);
      logic [7:0] msk;
      logic [7:0] off;
      if (lc == 3'b111) return s + 8'(b);
      msk = (lc == 3'b010) ? 8'h07 : 8'h03;
      off = ilv ? ((s & msk) ^ 8'(b)) : (((s & msk) + 8'(b)) & msk);
      return (s & ~msk) | off;
   endfunction

   // called at a negedge; the next rising edge is the start edge k
   task automatic launch(input logic [7:0] a, input logic [2:0] lc, input bit ilv,
                         input bit y2, input logic [3:0] xc, input bit early,
                         input int low_cycles);
      adr_in = a; cfg_len = lc; cfg_ilv = ilv; cfg_y2 = y2;
      cfg_xlat = xc; cfg_early = early; lat_n = 1'b0;
      @(negedge clk);
      adr_in = ~a;
      for (int i = 1; i < low_cycles; i++) @(negedge clk);
      lat_n = 1'b1;
   endtask

   task automatic word(input string req, input logic [7:0] s, input logic [2:0] lc,
                       input bit ilv, input int b);
      chk(req, "data_valid", data_valid, 1);
      chk(req, "mem_addr", mem_addr, exp_addr(s, lc, ilv, b));
      chk("R14", "dout", dout, data_of(exp_addr(s, lc, ilv, b)));
   endtask

   task automatic t_reset;
      chk("R1", "data_valid", data_valid, 0);
      chk("R1", "dout_en", dout_en, 0);
      chk("R1", "dout", dout, 0);
      chk("R1", "wait_n", wait_n, 1);
   endtask

   // sequential 4-word, latency 8, long strobe and scrambled inputs afterwards
   task automatic t_seq4;
      launch(8'h16, 3'b001, 0, 0, 4'd3, 0, 3);          // after edge k+2
      cfg_len = 3'b111; cfg_y2 = 1'b1; cfg_xlat = 4'd0; cfg_ilv = 1'b1;
      repeat (5) @(negedge clk);                        // k+7
      chk("R3", "valid before latency 8", data_valid, 0);
      @(negedge clk);                                   // k+8
      for (int b = 0; b < 4; b++) begin
         word("R5", 8'h16, 3'b001, 0, b);
         chk("R11", "wait_n fixed", wait_n, 1);
         @(negedge clk);
      end
      chk("R9", "valid after 4 words (R2 R4)", data_valid, 0);
      chk("R9", "dout_en after end", dout_en, 0);
   endtask

   task automatic t_ilv8;
      launch(8'h25, 3'b010, 1, 0, 4'd0, 0, 1);
      repeat (4) @(negedge clk);
      chk("R3", "valid before latency 5", data_valid, 0);
      @(negedge clk);
      for (int b = 0; b < 8; b++) begin
         word("R6", 8'h25, 3'b010, 1, b);
         @(negedge clk);
      end
      chk("R4", "valid after 8 words", data_valid, 0);
   endtask

   task automatic t_y2;
      launch(8'h42, 3'b001, 0, 1, 4'd1, 0, 1);
      repeat (6) @(negedge clk);
      for (int b = 0; b < 4; b++) begin
         for (int h = 0; h < 2; h++) begin
            word("R8", 8'h42, 3'b001, 0, b);
            @(negedge clk);
         end
      end
      chk("R9", "valid after two-clock burst", data_valid, 0);
   endtask

   // adv_n high on a non-sampling edge is ignored, on a sampling edge it holds
   task automatic t_hold_y2;
      launch(8'h90, 3'b111, 0, 1, 4'd0, 0, 1);
      repeat (5) @(negedge clk);                        // k+5
      word("R8", 8'h90, 3'b111, 0, 0);
      adv_n = 1'b1;
      @(negedge clk);                                   // k+6
      word("R8", 8'h90, 3'b111, 0, 0);
      @(negedge clk);                                   // k+7, held
      word("R8", 8'h90, 3'b111, 0, 0);
      adv_n = 1'b0;
      @(negedge clk);                                   // k+8
      word("R8", 8'h90, 3'b111, 0, 0);
      @(negedge clk);                                   // k+9
      word("R8", 8'h90, 3'b111, 0, 1);
      @(negedge clk);
      word("R8", 8'h90, 3'b111, 0, 1);
      @(negedge clk);
      word("R8", 8'h90, 3'b111, 0, 2);
   endtask

   task automatic t_suspend;
      launch(8'hA0, 3'b111, 0, 0, 4'd0, 0, 1);
      repeat (5) @(negedge clk);
      word("R10", 8'hA0, 3'b111, 0, 0);
      chk("R14", "dout_en", dout_en, 1);
      oe_n = 1'b1; adv_n = 1'b1;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk("R10", "dout_en suspended", dout_en, 0);
         chk("R10", "dout suspended", dout, 0);
         chk("R10", "mem_addr frozen", mem_addr, 8'hA0);
      end
      oe_n = 1'b0; adv_n = 1'b0;
      @(negedge clk);
      word("R10", 8'hA0, 3'b111, 0, 1);
      chk("R10", "dout_en resumed", dout_en, 1);
   endtask

   task automatic t_wrap;
      launch(8'hFC, 3'b111, 0, 0, 4'd0, 0, 1);
      repeat (4) @(negedge clk);
      chk("R11", "wait_n aligned before data", wait_n, 1);
      @(negedge clk);
      for (int b = 0; b < 6; b++) begin
         word("R7", 8'hFC, 3'b111, 0, b);
         chk("R11", "wait_n aligned", wait_n, 1);
         @(negedge clk);
      end
   endtask

   task automatic t_stall(input bit early);
      launch(8'h13, 3'b111, 0, 0, 4'd0, early, 1);
      repeat (4) @(negedge clk);                        // k+4
      chk("R12", "wait_n one before stall", wait_n, early ? 0 : 1);
      chk("R11", "valid during latency", data_valid, 0);
      @(negedge clk);                                   // k+5 stall
      chk("R12", "wait_n in stall", wait_n, early ? 1 : 0);
      chk("R11", "valid in stall", data_valid, 0);
      @(negedge clk);                                   // k+6
      word("R11", 8'h13, 3'b111, 0, 0);
      chk("R12", "wait_n after stall", wait_n, 1);
      @(negedge clk);
      word("R11", 8'h13, 3'b111, 0, 1);
   endtask

   // restart lands on an edge where adv_n is sampled low
   task automatic t_abort;
      launch(8'h30, 3'b010, 0, 0, 4'd0, 0, 1);
      repeat (5) @(negedge clk);
      word("R13", 8'h30, 3'b010, 0, 0);
      @(negedge clk);
      word("R13", 8'h30, 3'b010, 0, 1);
      launch(8'h57, 3'b001, 0, 0, 4'd0, 0, 1);          // after new edge k'
      chk("R13", "valid right after restart", data_valid, 0);
      repeat (4) @(negedge clk);
      chk("R13", "valid before new latency", data_valid, 0);
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
         word("R13", 8'h57, 3'b001, 0, b);
         @(negedge clk);
      end
      chk("R13", "valid after new burst", data_valid, 0);
   endtask

   task automatic gap;
      adv_n = 1'b0; oe_n = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_seq4;     gap;
      t_ilv8;     gap;
      t_y2;       gap;
      t_hold_y2;  gap;
      t_suspend;  gap;
      t_wrap;     gap;
      t_stall(0); gap;
      t_stall(1); gap;
      t_abort;    gap;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule